// File: doc/BRIEF.md
# Four-Level Strap Slave Address Decoder

This block decides which seven-bit bus address a serial slave answers to. Three strap pins pick the address. Each pin is wired at board level to one of four nets: ground, supply, the bus clock line or the bus data line. The pins have no pull-ups, so every strap is always driven by the net it is tied to. Three pins with four states each give 64 distinct addresses.

After reset the block watches the clock and data levels it receives and takes two snapshots of the straps. The first is taken while clock is high and data is low, which is the level pair of a START condition. The second is taken later, while clock is low and data is high. A strap that is low then high follows the data line. A strap that is high then low follows the clock line. A strap that is steady follows its rail. The resulting 6-bit code is frozen for the rest of the session and is turned into an address. From then on, each address byte that the slave engine delivers is compared with that address. An exact match gives a one-cycle match pulse, and the direction bit of the byte is presented alongside it.

Top module: `strap_addr_decoder`

## Requirements
- R1: While reset is asserted and immediately after it, `code_valid_o`, `match_o` and `rnw_o` are 0.
- R2: Strap k sets code bits [2k+1:2k] as follows: 0 for ground, 1 for supply, 2 for a strap that follows the clock line, 3 for a strap that follows the data line.
- R3: The first snapshot is the first clock edge after reset with clock high and data low. The second snapshot is the first later edge with clock low and data high. `code_valid_o` rises the cycle after the second snapshot and not before. A clock-low/data-high pair seen before the first snapshot does not count.
- R4: Once `code_valid_o` is 1 it stays 1, and `strap_code_o` and `own_addr_o` do not change, whatever the straps or the bus lines do later.
- R5: The 7-bit address is 10h+code for codes 0–31, 50h+(code−32) for codes 32–55 and 70h+(code−56) for codes 56–63. These are the even write-form bytes 20h–5Eh, A0h–CEh and E0h–EEh.
- R6: When `addr_valid_i` is 1 while the code is valid and `addr_byte_i[7:1]` equals the selected address, `match_o` is 1 in the next cycle only.
- R7: An address byte that differs in any of bits 7..1, or that arrives before the code is valid, gives no match.
- R8: Each address byte accepted while the code is valid loads `addr_byte_i[0]` into `rnw_o` in the next cycle, where 1 means read and 0 means write. `rnw_o` then holds until the next such byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| strap_i | input | 3 | Address strap pin levels |
| addr_valid_i | input | 1 | One-cycle strobe: address byte received |
| addr_byte_i | input | 8 | Address byte: address in 7..1, direction in 0 |
| code_valid_o | output | 1 | Strap code has been captured and frozen |
| strap_code_o | output | 6 | Captured strap code |
| own_addr_o | output | 7 | Selected slave address |
| match_o | output | 1 | One-cycle pulse on an exact address match |
| rnw_o | output | 1 | Direction of the last accepted address byte |

## Verification
The bench walks all 64 strap wirings and checks the code and the address of each one. A mistake in the range boundaries at codes 31/32 or 55/56 would put one wiring onto a neighbouring range's address. It checks the sampling order by presenting the low-phase level pair before any START. A design that accepted the snapshots in either order would lock onto a wrong code. It rewires the straps and moves the bus lines after lock to catch a design that keeps resampling. It also sends a matching byte before lock, and bytes that differ only in bit 1 or bit 7, to catch a compare that is too loose or that is armed too early.

// File: rtl/strap_addr_pkg.sv
package strap_addr_pkg;

    // Connection kind of one strap pin, as a 2-bit code field.
    typedef enum logic [1:0] {
        KIND_GND = 2'd0,
        KIND_VDD = 2'd1,
        KIND_SCL = 2'd2,
        KIND_SDA = 2'd3
    } strap_kind_e;

    // Capture progress after reset.
    typedef enum logic [1:0] {
        PH_SEEK_HI = 2'd0,
        PH_SEEK_LO = 2'd1,
        PH_LOCKED  = 2'd2
    } phase_e;

endpackage

// File: rtl/strap_classifier.sv
module strap_classifier
    import strap_addr_pkg::*;
(
    input  logic        hi_sample_i,  // level while clock high, data low
    input  logic        lo_sample_i,  // level while clock low, data high
    output strap_kind_e kind_o
);

    always_comb begin
        case ({hi_sample_i, lo_sample_i})
            2'b00:   kind_o = KIND_GND;
            2'b11:   kind_o = KIND_VDD;
            2'b10:   kind_o = KIND_SCL;
            default: kind_o = KIND_SDA;
        endcase
    end

endmodule

// File: rtl/strap_addr_lookup.sv
module strap_addr_lookup #(
    parameter int CODE_W    = 6,
    parameter int ADDR_W    = 7,
    parameter int R0_BASE   = 'h10,
    parameter int R0_LEN    = 32,
    parameter int R1_BASE   = 'h50,
    parameter int R1_LEN    = 24,
    parameter int R2_BASE   = 'h70
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] LIM0  = ADDR_W'(R0_LEN);
    localparam logic [ADDR_W-1:0] LIM1  = ADDR_W'(R0_LEN + R1_LEN);
    localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(R0_BASE);
    localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(R1_BASE);
    localparam logic [ADDR_W-1:0] BASE2 = ADDR_W'(R2_BASE);

    logic [ADDR_W-1:0] code_ext;

    always_comb begin
        code_ext = ADDR_W'(code_i);
        if (code_ext < LIM0)
            addr_o = BASE0 + code_ext;
        else if (code_ext < LIM1)
            addr_o = BASE1 + (code_ext - LIM0);
        else
            addr_o = BASE2 + (code_ext - LIM1);
    end

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
    import strap_addr_pkg::*;
#(
    parameter int NUM_STRAPS = 3,
    parameter int ADDR_W     = 7,
    localparam int KIND_W    = 2,
    localparam int CODE_W    = NUM_STRAPS * KIND_W,
    localparam int BYTE_W    = ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [NUM_STRAPS-1:0] strap_i,
    input  logic                  addr_valid_i,
    input  logic [BYTE_W-1:0]     addr_byte_i,
    output logic                  code_valid_o,
    output logic [CODE_W-1:0]     strap_code_o,
    output logic [ADDR_W-1:0]     own_addr_o,
    output logic                  match_o,
    output logic                  rnw_o
);

    typedef struct packed {
        phase_e                phase;
        logic [NUM_STRAPS-1:0] samp_hi;
        logic [NUM_STRAPS-1:0] samp_lo;
        logic                  match;
        logic                  rnw;
    } state_t;

    state_t s_d, s_q;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] own_addr;

    // One classifier per strap pin; each fills its own 2-bit code field.
    for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_pin
        strap_kind_e kind;
        strap_classifier u_cls (
            .hi_sample_i (s_q.samp_hi[k]),
            .lo_sample_i (s_q.samp_lo[k]),
            .kind_o      (kind)
        );
        assign code[k*KIND_W +: KIND_W] = kind;
    end

    strap_addr_lookup #(
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_lookup (
        .code_i (code),
        .addr_o (own_addr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.match = 1'b0;
        case (s_q.phase)
            PH_SEEK_HI: begin
                if (scl_i && !sda_i) begin
                    s_d.samp_hi = strap_i;
                    s_d.phase   = PH_SEEK_LO;
                end
            end
            PH_SEEK_LO: begin
                if (!scl_i && sda_i) begin
                    s_d.samp_lo = strap_i;
                    s_d.phase   = PH_LOCKED;
                end
            end
            PH_LOCKED: begin
                if (addr_valid_i) begin
                    s_d.rnw   = addr_byte_i[0];
                    s_d.match = (addr_byte_i[BYTE_W-1:1] == own_addr);
                end
            end
            default: s_d.phase = PH_SEEK_HI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_SEEK_HI, samp_hi: '0, samp_lo: '0,
                     match: 1'b0, rnw: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign code_valid_o = (s_q.phase == PH_LOCKED);
    assign strap_code_o = code;
    assign own_addr_o   = own_addr;
    assign match_o      = s_q.match;
    assign rnw_o        = s_q.rnw;

endmodule

// File: rtl/strap_addr_decoder_chk.sv
module strap_addr_decoder_chk #(
    parameter int CODE_W = 6,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid_i,
    input logic [ADDR_W-1:0] addr_hi_i,
    input logic              code_valid_o,
    input logic [CODE_W-1:0] strap_code_o,
    input logic [ADDR_W-1:0] own_addr_o,
    input logic              match_o,
    input logic              rnw_o
);

    assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> code_valid_o);

    assert_code_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> ($stable(strap_code_o) && $stable(own_addr_o)));

    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> ((own_addr_o >= 7'h10 && own_addr_o <= 7'h2F) ||
                          (own_addr_o >= 7'h50 && own_addr_o <= 7'h67) ||
                          (own_addr_o >= 7'h70 && own_addr_o <= 7'h77)));

    assert_match_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(addr_valid_i) && ($past(addr_hi_i) == own_addr_o)));

    assert_match_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> code_valid_o);

    assert_dir_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_i |=> $stable(rnw_o));

endmodule

bind strap_addr_decoder strap_addr_decoder_chk #(
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_i (addr_valid_i),
    .addr_hi_i    (addr_byte_i[BYTE_W-1:1]),
    .code_valid_o (code_valid_o),
    .strap_code_o (strap_code_o),
    .own_addr_o   (own_addr_o),
    .match_o      (match_o),
    .rnw_o        (rnw_o)
);

// File: tb/strap_addr_decoder_test.sv
module strap_addr_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [2:0] strap;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       code_valid;
    logic [5:0] strap_code;
    logic [6:0] own_addr;
    logic       match;
    logic       rnw;

    logic [1:0] wiring [3];
    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    // Board model: each strap follows the net it is wired to.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            case (wiring[k])
                2'd0:    strap[k] = 1'b0;
                2'd1:    strap[k] = 1'b1;
                2'd2:    strap[k] = scl;
                default: strap[k] = sda;
            endcase
        end
    end

    strap_addr_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda),
        .strap_i      (strap),
        .addr_valid_i (addr_valid),
        .addr_byte_i  (addr_byte),
        .code_valid_o (code_valid),
        .strap_code_o (strap_code),
        .own_addr_o   (own_addr),
        .match_o      (match),
        .rnw_o        (rnw)
    );

    function automatic int exp_addr(int c);
        if (c < 32)      return 'h10 + c;
        else if (c < 56) return 'h50 + (c - 32);
        else             return 'h70 + (c - 56);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_wiring(int c);
        for (int k = 0; k < 3; k++) wiring[k] = 2'(c >> (2 * k));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1; addr_valid = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // START level pair, then clock low, then data high: locks on the last edge.
    task automatic lock_seq();
        sda = 1'b0; step();
        scl = 1'b0; step();
        sda = 1'b1; step();
    endtask

    task automatic send_byte(logic [7:0] b);
        addr_byte = b; addr_valid = 1'b1; step();
        addr_valid = 1'b0;
    endtask

    task automatic test_reset();
        set_wiring(0);
        rst_n = 1'b0; step();
        check("R1 valid in reset", code_valid, 0);
        check("R1 match in reset", match, 0);
        do_reset();
        check("R1 valid after reset", code_valid, 0);
        check("R1 rnw after reset", rnw, 0);
    endtask

    task automatic test_sequence();
        set_wiring(6'b11_10_01);
        do_reset();
        scl = 1'b0; sda = 1'b1; step(); step();
        check("R3 low pair before START ignored", code_valid, 0);
        scl = 1'b1; step();
        sda = 1'b0; step();
        check("R3 not valid after first snapshot", code_valid, 0);
        scl = 1'b0; step();
        check("R3 not valid with clock low data low", code_valid, 0);
        sda = 1'b1; step();
        check("R3 valid after second snapshot", code_valid, 1);
        check("R2 mixed wiring code", strap_code, 6'b11_10_01);
    endtask

    task automatic test_all_codes();
        for (int c = 0; c < 64; c++) begin
            set_wiring(c);
            do_reset();
            lock_seq();
            check("R2 strap code", strap_code, c);
            check("R5 address", own_addr, exp_addr(c));
        end
    endtask

    task automatic test_freeze();
        set_wiring(27);
        do_reset();
        lock_seq();
        set_wiring(54);
        scl = 1'b1; sda = 1'b0; step();
        scl = 1'b0; sda = 1'b1; step();
        scl = 1'b1; step();
        check("R4 code frozen", strap_code, 27);
        check("R4 address frozen", own_addr, exp_addr(27));
        check("R4 valid held", code_valid, 1);
    endtask

    task automatic test_match();
        logic [6:0] a;
        set_wiring(45);
        do_reset();
        lock_seq();
        a = 7'(exp_addr(45));
        send_byte({a, 1'b1});
        check("R6 match on read byte", match, 1);
        check("R8 direction read", rnw, 1);
        step();
        check("R6 match lasts one cycle", match, 0);
        check("R8 direction held", rnw, 1);
        send_byte({a, 1'b0});
        check("R6 match on write byte", match, 1);
        check("R8 direction write", rnw, 0);
        step();
        check("R6 match low again", match, 0);
    endtask

    task automatic test_mismatch();
        logic [6:0] a;
        set_wiring(60);
        a = 7'(exp_addr(60));
        do_reset();
        send_byte({a, 1'b1});
        check("R7 no match before lock", match, 0);
        check("R7 direction untouched before lock", rnw, 0);
        lock_seq();
        send_byte({a ^ 7'h01, 1'b1});
        check("R7 bit 1 differs", match, 0);
        check("R8 direction from unmatched byte", rnw, 1);
        send_byte({a ^ 7'h40, 1'b0});
        check("R7 bit 7 differs", match, 0);
        send_byte({a, 1'b0});
        check("R6 exact match after misses", match, 1);
    endtask

    initial begin
        test_reset();
        test_sequence();
        test_all_codes();
        test_freeze();
        test_match();
        test_mismatch();
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule